// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller of an out-of-order pipeline. Instructions arrive in program order, already decoded into an operation class, a destination register and two source registers. Each cycle the controller decides whether the instruction at the head may enter a functional unit. It also decides which waiting units may fetch their operands from the register file and which finished units may write their result back. Five units are managed: one integer unit, two multipliers, one adder/subtractor and one divider. The arithmetic itself and the register file lie outside the block. A unit reports the end of its computation with a one-cycle completion pulse.

The controller keeps three pieces of state. For every unit it holds a progress phase (idle, awaiting operands, executing, awaiting write-back). For every unit it also holds a status record: destination, both source indices, the unit expected to produce each source, and a ready flag per source. Finally, a table records, for each of the 32 registers, which unit will next write it.

Ordering is enforced in three places. A destination clash between active instructions is caught at entry. A true dependence holds the reader until its producer has written back, and no result is forwarded. A name clash where a later writer would overwrite a value that an earlier reader still needs holds the writer back.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After synchronous reset all units are idle and every grant output is low. The first valid instruction is accepted in the same cycle it is presented.
- R2: `op` encodes 0 integer, 1 multiply, 2 add, 3 subtract, 4 divide; codes 5 to 7 route to the integer unit. Unit identifiers are 1 integer, 2 multiplier A, 3 multiplier B, 4 adder, 5 divider, and 0 means none. Bit k of every per-unit vector belongs to unit k+1. An instruction is accepted only into an idle unit of its class, and multiplier A is preferred over multiplier B.
- R3: An instruction whose destination is the destination of any active instruction is not accepted until that register's pending writer has been granted write-back.
- R4: `issue_ok` reflects the decision in the cycle the instruction is presented, and `stall` equals `in_valid` and not `issue_ok`. A held instruction is re-evaluated every cycle, and no later instruction passes it.
- R5: A unit receives `rd_grant` only when neither source has a pending writer that entered earlier. The grant comes no sooner than the cycle after that writer's write-back grant, and no sooner than the cycle after acceptance.
- R6: Each accepted instruction receives `rd_grant` for exactly one cycle.
- R7: A completion pulse counts only while its unit is executing, i.e. after its read grant. `wb_grant` follows no sooner than the cycle after the pulse.
- R8: A unit is refused write-back while any other unit has an unread source naming its destination, where that source does not wait on this very unit.
- R9: At most one `wb_grant` bit is high per cycle; among eligible units the lowest identifier wins.
- R10: After its write-back grant a unit is idle, and its destination register is free for a new writer from the next cycle.
- R11: A source whose pending writer is granted write-back in the very cycle the reader is accepted counts as ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented |
| in_op | input | 3 | Operation code (R2) |
| in_dst | input | 5 | Destination register index |
| in_src1 | input | 5 | First source register index |
| in_src2 | input | 5 | Second source register index |
| fu_done | input | 5 | Completion pulse per unit |
| issue_ok | output | 1 | Presented instruction is accepted this cycle |
| issue_unit | output | 3 | Identifier of the accepting unit, 0 when none |
| stall | output | 1 | Presented instruction is held |
| rd_grant | output | 5 | Per-unit operand-read permission |
| wb_grant | output | 5 | Per-unit write-back permission, at most one high |

## Verification
The bench builds the block with its default configuration of five units and 32 registers. The units are modelled as countdown stubs with latencies of 1 (integer), 10 (multiply), 2 (add) and 40 (divide). These small, distinct latencies make every grant cycle an arithmetic function of the acceptance cycle. They also let a simultaneous write-back race, a same-cycle write-back and acceptance, and a long-lived blocked writer all be set up on purpose. A sweep over every producer/consumer pairing of four registers covers both the dependent and the independent read timing.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int NUM_FU  = 5;
    localparam int FU_W    = 3;
    localparam int NUM_REG = 32;
    localparam int REG_W   = $clog2(NUM_REG);
    localparam int OP_W    = 3;

    typedef logic [FU_W-1:0]  fu_id_t;
    typedef logic [REG_W-1:0] reg_idx_t;

    localparam fu_id_t FU_NONE = '0;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPS  = 2'd1,
        PH_EXEC = 2'd2,
        PH_WB   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        CL_INT = 2'd0,
        CL_MUL = 2'd1,
        CL_ADD = 2'd2,
        CL_DIV = 2'd3
    } cls_e;

    typedef struct packed {
        phase_e   ph;
        reg_idx_t fi;
        reg_idx_t fj;
        reg_idx_t fk;
        fu_id_t   qj;
        fu_id_t   qk;
        logic     rj;
        logic     rk;
    } fu_stat_t;

    function automatic cls_e op_class(input logic [OP_W-1:0] op);
        case (op)
            3'd1:       return CL_MUL;
            3'd2, 3'd3: return CL_ADD;
            3'd4:       return CL_DIV;
            default:    return CL_INT;
        endcase
    endfunction

    function automatic cls_e unit_class(input int idx);
        case (idx)
            0:       return CL_INT;
            1, 2:    return CL_MUL;
            3:       return CL_ADD;
            default: return CL_DIV;
        endcase
    endfunction

endpackage

// File: rtl/sb_prio_pick.sv
module sb_prio_pick #(
    parameter int N   = 5,
    parameter int IDW = 3
) (
    input  logic [N-1:0]   req,
    output logic [N-1:0]   grant,
    output logic           any,
    output logic [IDW-1:0] id
);
    always_comb begin
        grant = '0;
        id    = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                grant    = '0;
                grant[k] = 1'b1;
                id       = IDW'(k + 1);
            end
        end
    end

    assign any = |req;
endmodule

// File: rtl/sb_unit_pick.sv
module sb_unit_pick
    import sb_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [NUM_FU-1:0] busy,
    output fu_id_t            unit,
    output logic              found
);
    logic [NUM_FU-1:0] cand;

    for (genvar i = 0; i < NUM_FU; i++) begin : g_cand
        assign cand[i] = !busy[i] && (unit_class(i) == op_class(op));
    end

    always_comb begin
        unit = FU_NONE;
        for (int k = NUM_FU - 1; k >= 0; k--) begin
            if (cand[k]) unit = fu_id_t'(k + 1);
        end
    end

    assign found = |cand;
endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
    parameter int NREG = 32,
    parameter int RW   = 5,
    parameter int IDW  = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      set_en,
    input  logic [RW-1:0]             set_idx,
    input  logic [IDW-1:0]            set_id,
    input  logic                      clr_en,
    input  logic [RW-1:0]             clr_idx,
    output logic [NREG-1:0][IDW-1:0]  owner
);
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [IDW-1:0] tag;
        always_ff @(posedge clk) begin
            if (rst) begin
                tag <= '0;
            end else if (set_en && set_idx == RW'(r)) begin
                tag <= set_id;
            end else if (clr_en && clr_idx == RW'(r)) begin
                tag <= '0;
            end
        end
        assign owner[r] = tag;
    end
endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
    import sb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [OP_W-1:0]    in_op,
    input  logic [REG_W-1:0]   in_dst,
    input  logic [REG_W-1:0]   in_src1,
    input  logic [REG_W-1:0]   in_src2,
    input  logic [NUM_FU-1:0]  fu_done,
    output logic               issue_ok,
    output logic [FU_W-1:0]    issue_unit,
    output logic               stall,
    output logic [NUM_FU-1:0]  rd_grant,
    output logic [NUM_FU-1:0]  wb_grant
);
    fu_stat_t [NUM_FU-1:0]           st;
    logic     [NUM_FU-1:0]           busy_vec;
    logic     [NUM_FU-1:0]           war_block;
    logic     [NUM_FU-1:0]           wb_req;
    logic     [NUM_REG-1:0][FU_W-1:0] owner;
    fu_id_t   pick_id, wb_id, q1_new, q2_new;
    logic     pick_any, wb_fire;
    reg_idx_t wb_dst;

    // unit selection and the entry decision
    sb_unit_pick u_pick (
        .op    (in_op),
        .busy  (busy_vec),
        .unit  (pick_id),
        .found (pick_any)
    );

    assign issue_ok   = in_valid && pick_any && (owner[in_dst] == FU_NONE);
    assign issue_unit = issue_ok ? pick_id : FU_NONE;
    assign stall      = in_valid && !issue_ok;

    // a writer leaving this cycle no longer counts as pending
    assign q1_new = (wb_fire && owner[in_src1] == wb_id) ? FU_NONE : owner[in_src1];
    assign q2_new = (wb_fire && owner[in_src2] == wb_id) ? FU_NONE : owner[in_src2];

    // write-back arbitration
    sb_prio_pick #(.N(NUM_FU), .IDW(FU_W)) u_wbarb (
        .req   (wb_req),
        .grant (wb_grant),
        .any   (wb_fire),
        .id    (wb_id)
    );

    always_comb begin
        wb_dst = '0;
        for (int k = 0; k < NUM_FU; k++) begin
            if (wb_grant[k]) wb_dst = st[k].fi;
        end
    end

    sb_reg_status #(.NREG(NUM_REG), .RW(REG_W), .IDW(FU_W)) u_rstat (
        .clk     (clk),
        .rst     (rst),
        .set_en  (issue_ok),
        .set_idx (in_dst),
        .set_id  (pick_id),
        .clr_en  (wb_fire),
        .clr_idx (wb_dst),
        .owner   (owner)
    );

    // per-unit status records
    for (genvar i = 0; i < NUM_FU; i++) begin : g_fu
        localparam fu_id_t MY_ID = fu_id_t'(i + 1);
        fu_stat_t s;
        logic     blk;

        always_ff @(posedge clk) begin
            if (rst) begin
                s <= '0;
            end else if (issue_ok && pick_id == MY_ID) begin
                s.ph <= PH_OPS;
                s.fi <= in_dst;
                s.fj <= in_src1;
                s.fk <= in_src2;
                s.qj <= q1_new;
                s.qk <= q2_new;
                s.rj <= (q1_new == FU_NONE);
                s.rk <= (q2_new == FU_NONE);
            end else if (wb_grant[i]) begin
                s.ph <= PH_IDLE;
                s.qj <= FU_NONE;
                s.qk <= FU_NONE;
                s.rj <= 1'b0;
                s.rk <= 1'b0;
            end else begin
                if (s.ph == PH_OPS && s.rj && s.rk) begin
                    s.ph <= PH_EXEC;
                    s.rj <= 1'b0;
                    s.rk <= 1'b0;
                end else if (s.ph == PH_EXEC && fu_done[i]) begin
                    s.ph <= PH_WB;
                end
                if (wb_fire && s.qj == wb_id) begin
                    s.rj <= 1'b1;
                    s.qj <= FU_NONE;
                end
                if (wb_fire && s.qk == wb_id) begin
                    s.rk <= 1'b1;
                    s.qk <= FU_NONE;
                end
            end
        end

        assign st[i]       = s;
        assign busy_vec[i] = (s.ph != PH_IDLE);
        assign rd_grant[i] = (s.ph == PH_OPS) && s.rj && s.rk;

        // another unit still needs the old value of this unit's destination
        always_comb begin
            blk = 1'b0;
            for (int f = 0; f < NUM_FU; f++) begin
                if (f != i && busy_vec[f] &&
                    ((st[f].rj && st[f].fj == s.fi) ||
                     (st[f].rk && st[f].fk == s.fi))) begin
                    blk = 1'b1;
                end
            end
        end

        assign war_block[i] = blk;
        assign wb_req[i]    = (s.ph == PH_WB) && !war_block[i];
    end
endmodule

// File: rtl/sb_hazard_ctrl_chk.sv
module sb_hazard_ctrl_chk
    import sb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [REG_W-1:0]  in_dst,
    input logic [REG_W-1:0]  in_src1,
    input logic [REG_W-1:0]  in_src2,
    input logic              issue_ok,
    input logic [FU_W-1:0]   issue_unit,
    input logic              stall,
    input logic [NUM_FU-1:0] rd_grant,
    input logic [NUM_FU-1:0] wb_grant,
    input logic [NUM_FU-1:0] busy_vec
);
    // shadow of the active instructions, rebuilt from the ports
    logic [NUM_FU-1:0]              sv, pend;
    logic [NUM_FU-1:0][REG_W-1:0]   sd, s1, s2;
    logic [NUM_FU-1:0][NUM_FU-1:0]  wm;

    p_stall_r4: assert property (@(posedge clk) disable iff (rst)
        stall |-> (in_valid && !issue_ok));

    p_wb_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_grant));

    for (genvar f = 0; f < NUM_FU; f++) begin : g_sh
        localparam logic [FU_W-1:0] F_ID = (FU_W)'(f + 1);
        logic                v, p;
        logic [REG_W-1:0]    d, a, b;
        logic [NUM_FU-1:0]   m;

        always_ff @(posedge clk) begin
            if (rst) begin
                v <= 1'b0; p <= 1'b0; m <= '0;
                d <= '0;   a <= '0;   b <= '0;
            end else if (issue_ok && issue_unit == F_ID) begin
                v <= 1'b1; p <= 1'b1;
                d <= in_dst; a <= in_src1; b <= in_src2;
                for (int g = 0; g < NUM_FU; g++) begin
                    m[g] <= sv[g] && !wb_grant[g] &&
                            (sd[g] == in_src1 || sd[g] == in_src2);
                end
            end else begin
                if (rd_grant[f]) p <= 1'b0;
                if (wb_grant[f]) v <= 1'b0;
                m <= m & ~wb_grant;
            end
        end

        assign sv[f] = v;  assign pend[f] = p;
        assign sd[f] = d;  assign s1[f] = a;  assign s2[f] = b;
        assign wm[f] = m;

        p_issue_idle_r2: assert property (@(posedge clk) disable iff (rst)
            (issue_ok && issue_unit == F_ID) |-> !busy_vec[f]);

        p_no_waw_r3: assert property (@(posedge clk) disable iff (rst)
            (issue_ok && sv[f]) |-> (sd[f] != in_dst));

        p_raw_wait_r5: assert property (@(posedge clk) disable iff (rst)
            rd_grant[f] |-> (wm[f] == '0));

        p_rd_once_r6: assert property (@(posedge clk) disable iff (rst)
            rd_grant[f] |=> !rd_grant[f]);

        p_wb_frees_r10: assert property (@(posedge clk) disable iff (rst)
            wb_grant[f] |=> !busy_vec[f]);

        for (genvar u = 0; u < NUM_FU; u++) begin : g_war
            if (u != f) begin : g_pair
                p_war_hold_r8: assert property (@(posedge clk) disable iff (rst)
                    (wb_grant[u] && pend[f] && !wm[f][u]) |->
                    (s1[f] != sd[u] && s2[f] != sd[u]));
            end
        end
    end
endmodule

bind sb_hazard_ctrl sb_hazard_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_dst     (in_dst),
    .in_src1    (in_src1),
    .in_src2    (in_src2),
    .issue_ok   (issue_ok),
    .issue_unit (issue_unit),
    .stall      (stall),
    .rd_grant   (rd_grant),
    .wb_grant   (wb_grant),
    .busy_vec   (busy_vec)
);

// File: tb/sb_hazard_ctrl_bench.sv
module sb_hazard_ctrl_bench;
    localparam int OPI = 0, OPM = 1, OPA = 2, OPS = 3, OPD = 4;

    logic       clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
    logic [2:0] in_op = '0;
    logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [4:0] fu_done, force_done = '0, stub_done;
    logic       issue_ok, stall;
    logic [2:0] issue_unit;
    logic [4:0] rd_grant, wb_grant;

    int cyc = 0, n_tests = 0, n_fail = 0;
    int rd_cyc [5], wb_cyc [5], rd_n [5], wb_n [5], cnt [5];
    bit finished = 0;

    sb_hazard_ctrl u_sb_hazard_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .fu_done(fu_done), .issue_ok(issue_ok), .issue_unit(issue_unit),
        .stall(stall), .rd_grant(rd_grant), .wb_grant(wb_grant)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int lat(input int i);
        case (i)
            0: return 1;
            1, 2: return 10;
            3: return 2;
            default: return 40;
        endcase
    endfunction

    // functional unit stubs: count down from the read grant
    always @(posedge clk) begin
        for (int i = 0; i < 5; i++) begin
            if (rst) cnt[i] <= 0;
            else if (rd_grant[i]) cnt[i] <= lat(i);
            else if (cnt[i] > 0) cnt[i] <= cnt[i] - 1;
        end
    end
    always_comb for (int i = 0; i < 5; i++) stub_done[i] = (cnt[i] == 1);
    assign fu_done = stub_done | force_done;

    always @(negedge clk) begin
        for (int i = 0; i < 5; i++) begin
            if (rd_grant[i]) begin rd_cyc[i] = cyc; rd_n[i]++; end
            if (wb_grant[i]) begin wb_cyc[i] = cyc; wb_n[i]++; end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr_log();
        for (int i = 0; i < 5; i++) begin
            rd_cyc[i] = -1; wb_cyc[i] = -1; rd_n[i] = 0; wb_n[i] = 0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // called just after a falling edge; returns one cycle after acceptance
    task automatic do_issue(input int op, input int d, input int a, input int b,
                            output int t, output int u, output int ns, output int fs);
        in_valid = 1'b1; in_op = 3'(op);
        in_dst = 5'(d); in_src1 = 5'(a); in_src2 = 5'(b);
        #1;
        fs = int'(stall); ns = 0;
        while (!issue_ok && ns < 2000) begin
            ns++;
            @(negedge clk); #2;
        end
        t = cyc; u = int'(issue_unit);
        @(negedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int tD, tA, tI, tM, tX, t1, t2, t3, u, uD, uA, uI, ns, fs;
        clr_log();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;

        // R1 reset state
        check("R1 rd_grant after reset", int'(rd_grant), 0);
        check("R1 wb_grant after reset", int'(wb_grant), 0);
        check("R1 stall after reset", int'(stall), 0);

        // divide / add / integer chain: RAW on F0, WAR on F8
        clr_log();
        do_issue(OPD, 0, 2, 4, tD, uD, ns, fs);
        check("R1 first instruction not stalled", fs, 0);
        check("R4 accepted in presenting cycle", ns, 0);
        do_issue(OPA, 10, 0, 8, tA, uA, ns, fs);
        do_issue(OPI, 8, 8, 14, tI, uI, ns, fs);
        check("R2 divide to unit 5", uD, 5);
        check("R2 add to unit 4", uA, 4);
        check("R2 integer to unit 1", uI, 1);
        check("R4 back-to-back add accepted", tA, tD + 1);
        check("R4 back-to-back integer accepted", tI, tD + 2);
        idle(5);
        force_done = 5'b01000;    // spurious pulse to the waiting adder
        idle(1);
        force_done = '0;
        idle(60);
        check("R5 divide read after issue", rd_cyc[4], tD + 1);
        check("R7 divide write-back", wb_cyc[4], tD + 42);
        check("R5 add read after divide write-back", rd_cyc[3], tD + 43);
        check("R5 integer read", rd_cyc[0], tI + 1);
        check("R8 integer write-back held until add read", wb_cyc[0], tD + 44);
        check("R7 add write-back ignores spurious pulse", wb_cyc[3], tD + 46);
        check("R7 add single write-back", wb_n[3], 1);
        check("R6 add single read", rd_n[3], 1);
        check("R6 divide single read", rd_n[4], 1);

        // R3 destination clash
        clr_log();
        do_issue(OPM, 6, 1, 1, tM, u, ns, fs);
        check("R2 first multiply to unit 2", u, 2);
        do_issue(OPS, 6, 2, 3, tX, u, ns, fs);
        check("R3 clash stalls", fs, 1);
        check("R3 stall cycles", ns, 12);
        check("R10 accepted after write-back", tX, tM + 13);
        check("R2 subtract to unit 4", u, 4);
        idle(20);

        // R2 multiplier sharing and structural stall
        clr_log();
        do_issue(OPM, 11, 1, 2, t1, u, ns, fs);
        check("R2 multiplier A first", u, 2);
        do_issue(OPM, 12, 1, 2, t2, u, ns, fs);
        check("R2 multiplier B second", u, 3);
        do_issue(OPM, 13, 1, 2, t3, u, ns, fs);
        check("R2 third multiply waits", ns, 11);
        check("R10 reuse of multiplier A", u, 2);
        check("R10 reuse cycle", t3, t1 + 13);
        idle(20);
        check("R7 multiplier B write-back", wb_cyc[2], t1 + 13);

        // R9 simultaneous write-back requests
        clr_log();
        do_issue(OPA, 20, 1, 2, tA, u, ns, fs);
        do_issue(OPI, 21, 1, 2, tI, u, ns, fs);
        idle(10);
        check("R9 integer wins race", wb_cyc[0], tA + 4);
        check("R9 adder granted next", wb_cyc[3], tA + 5);

        // R11 acceptance in the producer's write-back cycle
        clr_log();
        do_issue(OPI, 3, 1, 1, tI, u, ns, fs);
        idle(2);
        check("R11 producer writing now", int'(wb_grant), 1);
        do_issue(OPA, 9, 3, 3, tA, u, ns, fs);
        check("R11 consumer accepted", tA, tI + 3);
        idle(10);
        check("R11 consumer reads next cycle", rd_cyc[3], tI + 4);

        // R7 pulse to an idle unit
        clr_log();
        force_done = 5'b00100;
        idle(1);
        force_done = '0;
        idle(3);
        check("R7 idle pulse gives no write-back", wb_n[2], 0);
        do_issue(OPM, 14, 1, 1, t1, u, ns, fs);
        do_issue(OPM, 15, 1, 1, t2, u, ns, fs);
        idle(20);
        check("R7 multiplier B normal after idle pulse", wb_cyc[2], t1 + 13);

        // R5 sweep: integer producer into add consumer
        for (int d = 0; d < 4; d++) begin
            for (int s = 0; s < 4; s++) begin
                clr_log();
                do_issue(OPI, d, 5, 6, tI, u, ns, fs);
                do_issue(OPA, 20, s, 7, tA, u, ns, fs);
                idle(8);
                check($sformatf("R5 sweep d%0d s%0d read cycle", d, s),
                      rd_cyc[3] - tI, (s == d) ? 4 : 2);
            end
        end

        finish_run();
    end
endmodule